// File: doc/BRIEF.md
# SPI Master with Selectable Slave-Select Handling

This block is a byte-wide SPI master that a processor drives through a control register and a data register. Writing the data register while the block is enabled and idle starts one full-duplex 8-bit exchange. The byte goes out on MOSI with the most significant bit first, and the byte from the slave is collected from MISO at the same time. At the end of the exchange the received byte is placed in a receive buffer, a completion flag is set, and an interrupt can be raised.

The slave-select pin has three uses, chosen by a two-bit field in the control register. In multi-master mode, which is the reset default, the pin is an input. Another master pulling it low takes the bus from this block: both enables are cleared and a sticky fault flag is set. In 3-wire mode the pin is ignored and not driven. In 4-wire mode the pin is an output whose level software sets directly.

SCK idles low and runs at the system clock divided by the even parameter `CLK_DIV`. MOSI changes on the falling edge of SCK and MISO is sampled on the rising edge.

Top module: `spi_nss_master`

## Requirements
- R1: After reset the control register reads 0x04 (mode field 01, every other bit 0), the data read port reads 0x00, SCK is 0, irq is 0 and nss_oe is 0.
- R2: A data write while spi_en (bit 0) and master_en (bit 6) are both 1 and busy is 0 starts a transfer. SCK gives exactly 8 pulses with a period of CLK_DIV clocks. MOSI carries the written byte MSB first, changes only while SCK is low, and the slave sees it on each rising SCK edge. The done flag becomes visible 16*(CLK_DIV/2)+1 cycles after the write cycle.
- R3: MISO is sampled on each rising SCK edge, MSB first. When the transfer completes, the data read port returns the full received byte.
- R4: The done flag (bit 7) is set at the end of every completed transfer. The busy bit (bit 1, read-only) reads 1 from the cycle after the starting write until the cycle in which done is set, and 0 from then on.
- R5: A data write made while busy is 1 is ignored: the byte on MOSI is unchanged and SCK still gives exactly 8 pulses.
- R6: The done flag and the fault flag (bit 5) stay set until a control write places 0 in that bit. A control write with 1 in that bit leaves the flag unchanged.
- R7: irq is 1 exactly when irq_en (bit 4) is 1 and done or fault is 1.
- R8: With mode field 01, NSS low while both enables are 1 clears master_en and spi_en and sets the fault flag, after a two-flop synchroniser. The enables stay 0 after NSS returns high, until software writes them again.
- R9: A fault during a transfer aborts it at once: SCK returns to 0, busy drops, done stays 0 and the data read port keeps its previous value.
- R10: With mode field 00, NSS has no effect (a low level raises no fault and transfers complete normally) and nss_oe is 0.
- R11: With mode field bit 3 at 1, nss_oe is 1 and nss_out equals mode bit 2.
- R12: A data write while spi_en or master_en is 0 starts nothing: SCK stays 0 and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_rdata | output | 8 | Control register read value, including the busy bit |
| data_we | input | 1 | Data register write strobe; starts a transfer |
| data_wdata | input | 8 | Byte to transmit |
| data_rdata | output | 8 | Receive buffer |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_in | input | 1 | Slave-select pin, input side |
| nss_out | output | 1 | Slave-select pin, output level |
| nss_oe | output | 1 | Slave-select pin, output enable |

## Verification
The assertions assume the following about the inputs:
- CLK_DIV is an even number of at least 2.
- Software writes the control register only in ways the requirements describe, so the busy bit is the only thing that makes SCK move.
- NSS is a slow level. It may change at any clock, and a low pulse lasting longer than the synchroniser is meant as a fault.

The stimulus changes inputs only at falling clock edges. It holds NSS low for several cycles whenever a fault is intended, and it switches modes only between transfers. The one exception is the planned abort, which occurs in the middle of a transfer.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [1:0] {
        NSS_3WIRE = 2'b00,
        NSS_MULTI = 2'b01,
        NSS_4W_LO = 2'b10,
        NSS_4W_HI = 2'b11
    } nss_mode_e;

    // stored control state, packed in read-back bit order except busy
    typedef struct packed {
        logic      done;
        logic      mst_en;
        logic      fault;
        logic      irq_en;
        nss_mode_e mode;
        logic      spi_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        done: 1'b0, mst_en: 1'b0, fault: 1'b0, irq_en: 1'b0,
        mode: NSS_MULTI, spi_en: 1'b0
    };

    function automatic logic [7:0] ctrl_pack(ctrl_t c, logic busy);
        return {c.done, c.mst_en, c.fault, c.irq_en, c.mode, busy, c.spi_en};
    endfunction

    function automatic logic is_four_wire(nss_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       xfer_finish,
    input  logic       mode_fault,
    output ctrl_t      q
);

    ctrl_t nxt;
    logic  unused_busy_wr;

    assign unused_busy_wr = wr_data[1];

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt.spi_en = wr_data[0];
            nxt.mode   = nss_mode_e'(wr_data[3:2]);
            nxt.irq_en = wr_data[4];
            nxt.mst_en = wr_data[6];
            // flags only clear on write-0
            nxt.fault  = q.fault & wr_data[5];
            nxt.done   = q.done & wr_data[7];
        end
        if (xfer_finish) begin
            nxt.done = 1'b1;
        end
        if (mode_fault) begin
            nxt.spi_en = 1'b0;
            nxt.mst_en = 1'b0;
            nxt.fault  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_RESET;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/spi_nss_unit.sv
module spi_nss_unit
    import spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  nss_mode_e mode,
    input  logic      enabled,
    input  logic      nss_in,
    output logic      fault,
    output logic      nss_out,
    output logic      nss_oe
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= nss_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], nss_in};
            end
        end
    endgenerate

    assign fault   = (mode == NSS_MULTI) && !sync_q[SYNC_STAGES-1] && enabled;
    assign nss_oe  = is_four_wire(mode);
    assign nss_out = is_four_wire(mode) ? mode[0] : 1'b1;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              abort,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] rx_buf,
    output logic              sck,
    output logic              mosi
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = $clog2(DATA_W + 1);

    logic [CW-1:0]     div_cnt;
    logic [BW-1:0]     bit_cnt;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic              tick;

    assign tick   = busy && (div_cnt == CW'(HALF - 1));
    assign finish = tick && sck && (bit_cnt == BW'(DATA_W)) && !abort;
    assign mosi   = tx_sr[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_buf  <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            div_cnt <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                sck     <= 1'b0;
                div_cnt <= '0;
                bit_cnt <= '0;
                tx_sr   <= tx_byte;
            end
        end else if (tick) begin
            div_cnt <= '0;
            if (!sck) begin
                sck     <= 1'b1;
                rx_sr   <= {rx_sr[DATA_W-2:0], miso};
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                sck <= 1'b0;
                if (bit_cnt == BW'(DATA_W)) begin
                    busy   <= 1'b0;
                    rx_buf <= rx_sr;
                end else begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_nss_master.sv
module spi_nss_master
    import spi_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    input  logic       data_we,
    input  logic [7:0] data_wdata,
    output logic [7:0] data_rdata,
    output logic       irq,
    output logic       sck,
    output logic       mosi,
    input  logic       miso,
    input  logic       nss_in,
    output logic       nss_out,
    output logic       nss_oe
);

    localparam int DATA_W = 8;

    ctrl_t ctrl_q;
    logic  busy;
    logic  finish;
    logic  fault;
    logic  enabled;
    logic  start;

    assign enabled = ctrl_q.spi_en && ctrl_q.mst_en;
    assign start   = data_we && enabled && !fault;

    spi_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ctrl_we),
        .wr_data     (ctrl_wdata),
        .xfer_finish (finish),
        .mode_fault  (fault),
        .q           (ctrl_q)
    );

    spi_nss_unit #(.SYNC_STAGES(SYNC_STAGES)) u_nss (
        .clk     (clk),
        .rst     (rst),
        .mode    (ctrl_q.mode),
        .enabled (enabled),
        .nss_in  (nss_in),
        .fault   (fault),
        .nss_out (nss_out),
        .nss_oe  (nss_oe)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tx_byte (data_wdata),
        .abort   (fault || !enabled),
        .miso    (miso),
        .busy    (busy),
        .finish  (finish),
        .rx_buf  (data_rdata),
        .sck     (sck),
        .mosi    (mosi)
    );

    assign ctrl_rdata = ctrl_pack(ctrl_q, busy);
    assign irq        = ctrl_q.irq_en && (ctrl_q.done || ctrl_q.fault);

endmodule

// File: rtl/spi_nss_master_chk.sv
module spi_nss_master_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctrl_rdata,
    input logic       sck,
    input logic       mosi,
    input logic       irq,
    input logic       nss_oe
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[1] |-> !sck);                                       // R2

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));                                         // R2

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rdata[7]) |-> ($past(ctrl_rdata[1]) && !ctrl_rdata[1])); // R4

    AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rdata[5]) |-> (!ctrl_rdata[6] && !ctrl_rdata[0]));   // R8

    AST_FAULT_STOPS_SCK: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rdata[5]) |-> !sck);                                 // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[4] |-> !irq);                                       // R7

    AST_NSS_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[3] |-> !nss_oe);                                    // R10

endmodule

bind spi_nss_master spi_nss_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_rdata (ctrl_rdata),
    .sck        (sck),
    .mosi       (mosi),
    .irq        (irq),
    .nss_oe     (nss_oe)
);

// File: tb/spi_nss_master_tb.sv
module spi_nss_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int HALF       = DIV / 2;
    localparam int XFER_WAIT  = 16 * HALF + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;
    logic       irq, sck, mosi, miso, nss_out, nss_oe;
    logic       nss_in = 1'b1;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // slave model
    int         rise_cnt = 0;
    int         fall_cnt = 0;
    int         fall_base = 0;
    int         bit_idx;
    logic [7:0] slv_pat = '0;
    logic [7:0] slv_rx  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_nss_master #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .data_we(data_we), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
        .nss_in(nss_in), .nss_out(nss_out), .nss_oe(nss_oe)
    );

    assign bit_idx = fall_cnt - fall_base;
    assign miso    = (bit_idx >= 0 && bit_idx < 8) ? slv_pat[7 - bit_idx] : 1'b0;

    always @(posedge sck) begin
        slv_rx   <= {slv_rx[6:0], mosi};
        rise_cnt <= rise_cnt + 1;
    end
    always @(negedge sck) fall_cnt <= fall_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one complete transfer; mid=1 adds an ignored write while busy (R5)
    task automatic xfer(input logic [7:0] tx, input logic [7:0] pat, input bit mid);
        int n;
        int rbase;
        rbase     = rise_cnt;
        fall_base = fall_cnt;
        slv_pat   = pat;
        @(negedge clk);
        data_we = 1'b1; data_wdata = tx;
        @(negedge clk);
        data_we = 1'b0;
        n = 1;
        check(ctrl_rdata[1] == 1'b1, "R4 busy after start", ctrl_rdata[1], 1);
        while (!ctrl_rdata[7] && n < 500) begin
            if (n == 5 && mid) begin data_we = 1'b1; data_wdata = ~tx; end
            else data_we = 1'b0;
            @(negedge clk);
            n++;
        end
        data_we = 1'b0;
        check(n == XFER_WAIT, "R2 transfer length", n, XFER_WAIT);
        check(slv_rx == tx, mid ? "R5 mosi byte" : "R2 mosi byte", slv_rx, tx);
        check(rise_cnt - rbase == 8, mid ? "R5 sck pulses" : "R2 sck pulses", rise_cnt - rbase, 8);
        check(data_rdata == pat, "R3 received byte", data_rdata, pat);
        check(ctrl_rdata[1] == 1'b0, "R4 busy clear at done", ctrl_rdata[1], 0);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        check(1'b0, "watchdog", cycles, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1
        check(ctrl_rdata == 8'h04, "R1 ctrl reset", ctrl_rdata, 8'h04);
        check(data_rdata == 8'h00, "R1 data reset", data_rdata, 0);
        check(sck == 1'b0 && irq == 1'b0 && nss_oe == 1'b0, "R1 pins reset",
              {sck, irq, nss_oe}, 0);

        // R12: disabled writes do nothing
        begin
            int r0;
            r0 = rise_cnt;
            wr_ctrl(8'h44);
            @(negedge clk); data_we = 1'b1; data_wdata = 8'hA5;
            @(negedge clk); data_we = 1'b0;
            check(ctrl_rdata[1] == 1'b0, "R12 busy stays 0", ctrl_rdata[1], 0);
            idle(40);
            check(rise_cnt == r0 && sck == 1'b0, "R12 no sck", rise_cnt - r0, 0);
        end

        // sweep of byte pairs in multi-master mode, irq enabled
        wr_ctrl(8'h55);
        for (int i = 0; i < 66; i++) begin
            logic [7:0] tx, pat;
            tx  = (i == 64) ? 8'hFF : (i == 65) ? 8'h00 : 8'((i * 37 + 5) & 255);
            pat = (i == 64) ? 8'h00 : (i == 65) ? 8'hFF : 8'((i * 91 + 3) & 255);
            xfer(tx, pat, 1'b0);
            check(irq == 1'b1, "R7 irq on done", irq, 1);
            wr_ctrl(8'h55);
            check(ctrl_rdata[7] == 1'b0 && irq == 1'b0, "R6 done cleared by 0",
                  ctrl_rdata, 8'h55);
        end

        // R6 write 1 keeps flag; R7 masking
        xfer(8'h3C, 8'hC3, 1'b0);
        wr_ctrl(8'hD5);
        check(ctrl_rdata == 8'hD5, "R6 done kept on write 1", ctrl_rdata, 8'hD5);
        wr_ctrl(8'hC5);
        check(irq == 1'b0, "R7 irq masked", irq, 0);
        wr_ctrl(8'hD5);
        check(irq == 1'b1, "R7 irq unmasked", irq, 1);
        wr_ctrl(8'h55);

        // R5 write during busy ignored
        xfer(8'h96, 8'h69, 1'b1);
        wr_ctrl(8'h55);

        // R8 fault in idle
        nss_in = 1'b0;
        idle(4);
        check(ctrl_rdata == 8'h34, "R8 fault clears enables", ctrl_rdata, 8'h34);
        check(irq == 1'b1, "R7 irq on fault", irq, 1);
        nss_in = 1'b1;
        idle(4);
        check(ctrl_rdata == 8'h34, "R8 stays disabled", ctrl_rdata, 8'h34);
        wr_ctrl(8'h75);
        check(ctrl_rdata == 8'h75, "R6 fault kept on write 1", ctrl_rdata, 8'h75);
        wr_ctrl(8'h55);
        idle(3);
        check(ctrl_rdata == 8'h55, "R8 re-enabled", ctrl_rdata, 8'h55);

        // R9 abort mid transfer
        begin
            logic [7:0] prev;
            prev = data_rdata;
            fall_base = fall_cnt;
            slv_pat = 8'hE7;
            @(negedge clk); data_we = 1'b1; data_wdata = 8'h18;
            @(negedge clk); data_we = 1'b0;
            idle(10);
            nss_in = 1'b0;
            idle(4);
            check(ctrl_rdata == 8'h34, "R9 abort flags", ctrl_rdata, 8'h34);
            check(sck == 1'b0, "R9 sck idle", sck, 0);
            check(data_rdata == prev, "R9 buffer unchanged", data_rdata, prev);
            nss_in = 1'b1;
            idle(4);
        end

        // R10 3-wire: nss ignored
        wr_ctrl(8'h41);
        nss_in = 1'b0;
        idle(4);
        check(nss_oe == 1'b0, "R10 nss not driven", nss_oe, 0);
        xfer(8'h5A, 8'hA5, 1'b0);
        check(ctrl_rdata == 8'hC1, "R10 no fault", ctrl_rdata, 8'hC1);
        nss_in = 1'b1;

        // R11 4-wire output
        wr_ctrl(8'h4D);
        check(nss_oe == 1'b1 && nss_out == 1'b1, "R11 nss high", {nss_oe, nss_out}, 3);
        wr_ctrl(8'h49);
        check(nss_oe == 1'b1 && nss_out == 1'b0, "R11 nss low", {nss_oe, nss_out}, 2);
        nss_in = 1'b0;
        xfer(8'hC7, 8'h7C, 1'b0);
        check(ctrl_rdata[5] == 1'b0, "R11 no fault in 4-wire", ctrl_rdata[5], 0);
        nss_in = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule